// File: doc/BRIEF.md
# Serial switch register access master

This block lets on-chip logic read and write the configuration registers and statistics counters of an external Ethernet switch through a three-wire serial link: a chip select, a clock and one bidirectional data line. A client presents one request: read or write, a table select (registers or counters), an address and 16 bits of write data. The block frames the command, clocks it out most significant bit first, and for reads turns the data line around and clocks in 32 bits. It then returns the result with a one-cycle done pulse.

The system clock is divided so that one timing unit lasts `CLK_PER_US` cycles, which gives 1 µs. Every clock-low and clock-high phase on the link lasts `EDGE_US` units. Outgoing data and chip select change only at the start of a low phase, so each is set up a full phase before the rising edge that the target uses. Each pin has its own output enable so that the pad can tristate it. All three pins are released when no transaction is running.

Top module: `swcfg_serial_master`

## Requirements
- R1: A request with `req_valid` high while `busy` is low is accepted at that clock edge. `busy` is high from the next cycle until the cycle of the one-cycle `done` pulse, in which it is low again. Requests made while `busy` is high are ignored and produce no extra transaction.
- R2: In the first cycle of a transaction, all three output enables are 1 and chip select, serial clock and data out are all 0.
- R3: Data out and chip select change only while the serial clock is low. Every low phase and every high phase of the serial clock lasts at least `EDGE_US*CLK_PER_US` system cycles.
- R4: A read sends 46 command bits, most significant first: 32 ones, then 0,1, then 1,0, then the table bit (0 = registers, 1 = counters), then two 0 bits, then address bits 6 down to 0. Chip select stays 0 for the whole read.
- R5: A write sends 27 command bits with chip select 1: a 1, then 0,1, then address bits 7 down to 0, then write data bits 15 down to 0.
- R6: After the last read command bit, `dio_oe` is 0. On each of the next 32 rising serial-clock edges, `dio_i` is sampled, most significant bit first.
- R7: After the command (and after the read data, for a read), exactly two more serial-clock pulses are issued with chip select 0. All three output enables are then 0 from the `done` cycle onward, so the link carries 48 clock pulses per read (the 46 command bits plus two) plus the 32 data pulses, and 29 per write.
- R8: For a register-table read, `rd_data[15:0]` is the first 16 bits received when the address is odd and the last 16 bits received when it is even. `rd_data[31:16]` is 0.
- R9: A counter-table read returns all 32 received bits on `rd_data`, first received in bit 31.
- R10: On a read, address bit 7 is ignored: it does not appear in the frame and does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_table | input | 1 | 0 = register table, 1 = counter table (reads) |
| req_addr | input | 8 | Register or counter address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Read result, valid from the done cycle |
| cs_o | output | 1 | Chip select level |
| cs_oe | output | 1 | Chip select output enable |
| sk_o | output | 1 | Serial clock level |
| sk_oe | output | 1 | Serial clock output enable |
| dio_o | output | 1 | Data out level |
| dio_oe | output | 1 | Data out enable (0 while receiving) |
| dio_i | input | 1 | Data in from the pad |

## Verification
The assertions assume that reset is applied at the start of the run and that `dio_i` is stable around each rising serial-clock edge. They place no limits on `req_valid`, so requests during `busy` are legal input. The bench models the target: it changes `dio_i` only on falling serial-clock edges, strobes requests for one cycle, and also strobes a deliberately ignored request partway through some transactions.

// File: rtl/swcfg_pkg.sv
package swcfg_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_LOW,
    SQ_HIGH,
    SQ_TAIL
  } seq_state_t;

  localparam int FRAME_W    = 46;
  localparam int RD_CMD_LEN = 46;
  localparam int WR_CMD_LEN = 27;
  localparam int RD_DATA_N  = 32;
  localparam int TAIL_CLKS  = 2;
  localparam int IDX_W      = 7;
endpackage

// File: rtl/swcfg_tick.sv
module swcfg_tick #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/swcfg_timer.sv
module swcfg_timer #(
  parameter int DIV   = 50,
  parameter int UNITS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expired
);
  localparam int UW = (UNITS > 1) ? $clog2(UNITS) : 1;
  localparam logic [UW-1:0] ULAST = UW'(UNITS - 1);

  logic          tick;
  logic          run;
  logic [UW-1:0] ucnt;

  swcfg_tick #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .clr  (start),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      ucnt    <= '0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (start) begin
        run  <= 1'b1;
        ucnt <= '0;
      end else if (run && tick) begin
        if (ucnt == ULAST) begin
          run     <= 1'b0;
          expired <= 1'b1;
        end else begin
          ucnt <= ucnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/swcfg_frame.sv
module swcfg_frame
  import swcfg_pkg::*;
(
  input  logic               wr,
  input  logic               tbl,
  input  logic [7:0]         addr,
  input  logic [15:0]        wdata,
  output logic [FRAME_W-1:0] bits,
  output logic [IDX_W-1:0]   len
);
  always_comb begin
    if (wr) begin
      bits = {1'b1, 2'b01, addr, wdata, 19'd0};
      len  = IDX_W'(WR_CMD_LEN);
    end else begin
      bits = {32'hFFFF_FFFF, 2'b01, 2'b10, tbl, 2'b00, addr[6:0]};
      len  = IDX_W'(RD_CMD_LEN);
    end
  end
endmodule

// File: rtl/swcfg_rdsel.sv
module swcfg_rdsel (
  input  logic        tbl,
  input  logic        odd,
  input  logic [31:0] raw,
  output logic [31:0] result
);
  always_comb begin
    if (tbl)      result = raw;
    else if (odd) result = {16'h0000, raw[31:16]};
    else          result = {16'h0000, raw[15:0]};
  end
endmodule

// File: rtl/swcfg_serial_master.sv
module swcfg_serial_master
  import swcfg_pkg::*;
#(
  parameter int CLK_PER_US = 250,
  parameter int EDGE_US    = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_table,
  input  logic [7:0]  req_addr,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [31:0] rd_data,
  output logic        cs_o,
  output logic        cs_oe,
  output logic        sk_o,
  output logic        sk_oe,
  output logic        dio_o,
  output logic        dio_oe,
  input  logic        dio_i
);
  localparam logic [IDX_W-1:0] DATA_N = IDX_W'(RD_DATA_N);
  localparam logic [IDX_W-1:0] TAIL_N = IDX_W'(TAIL_CLKS);

  seq_state_t         st;
  logic [FRAME_W-1:0] cmd_sr;
  logic [IDX_W-1:0]   cmd_len;
  logic [IDX_W-1:0]   tot_len;
  logic [IDX_W-1:0]   bit_idx;
  logic [IDX_W-1:0]   nxt_idx;
  logic [31:0]        rx_sr;
  logic [31:0]        rx_sel;
  logic               op_write;
  logic               op_table;
  logic               op_odd;
  logic               tstart;
  logic               tdone;
  logic               in_rx;
  logic [FRAME_W-1:0] f_bits;
  logic [IDX_W-1:0]   f_len;

  swcfg_frame u_frame (
    .wr    (req_write),
    .tbl   (req_table),
    .addr  (req_addr),
    .wdata (req_wdata),
    .bits  (f_bits),
    .len   (f_len)
  );

  swcfg_timer #(.DIV(CLK_PER_US), .UNITS(EDGE_US)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (tstart),
    .expired (tdone)
  );

  swcfg_rdsel u_rdsel (
    .tbl    (op_table),
    .odd    (op_odd),
    .raw    (rx_sr),
    .result (rx_sel)
  );

  assign tstart  = (st == SQ_IDLE) ? req_valid : tdone;
  assign nxt_idx = bit_idx + 1'b1;
  assign in_rx   = !op_write && (bit_idx >= cmd_len) && (bit_idx < cmd_len + DATA_N);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      cmd_sr   <= '0;
      cmd_len  <= '0;
      tot_len  <= '0;
      bit_idx  <= '0;
      rx_sr    <= '0;
      op_write <= 1'b0;
      op_table <= 1'b0;
      op_odd   <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      rd_data  <= '0;
      cs_o     <= 1'b0;
      cs_oe    <= 1'b0;
      sk_o     <= 1'b0;
      sk_oe    <= 1'b0;
      dio_o    <= 1'b0;
      dio_oe   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        SQ_IDLE: begin
          if (req_valid) begin
            op_write <= req_write;
            op_table <= req_table;
            op_odd   <= req_addr[0];
            cmd_sr   <= f_bits;
            cmd_len  <= f_len;
            tot_len  <= f_len + (req_write ? '0 : DATA_N) + TAIL_N;
            bit_idx  <= '0;
            busy     <= 1'b1;
            cs_oe    <= 1'b1;
            sk_oe    <= 1'b1;
            dio_oe   <= 1'b1;
            cs_o     <= 1'b0;
            sk_o     <= 1'b0;
            dio_o    <= 1'b0;
            st       <= SQ_SETUP;
          end
        end
        SQ_SETUP: begin
          if (tdone) begin
            cs_o   <= op_write;
            dio_o  <= cmd_sr[FRAME_W-1];
            cmd_sr <= {cmd_sr[FRAME_W-2:0], 1'b0};
            st     <= SQ_LOW;
          end
        end
        SQ_LOW: begin
          if (tdone) begin
            sk_o <= 1'b1;
            if (in_rx) rx_sr <= {rx_sr[30:0], dio_i};
            st <= SQ_HIGH;
          end
        end
        SQ_HIGH: begin
          if (tdone) begin
            sk_o <= 1'b0;
            if (nxt_idx == tot_len) begin
              cs_o  <= 1'b0;
              dio_o <= 1'b0;
              st    <= SQ_TAIL;
            end else begin
              bit_idx <= nxt_idx;
              st      <= SQ_LOW;
              if (nxt_idx < cmd_len) begin
                cs_o   <= op_write;
                dio_o  <= cmd_sr[FRAME_W-1];
                cmd_sr <= {cmd_sr[FRAME_W-2:0], 1'b0};
              end else begin
                cs_o  <= 1'b0;
                dio_o <= 1'b0;
                if (!op_write && nxt_idx == cmd_len) dio_oe <= 1'b0;
              end
            end
          end
        end
        SQ_TAIL: begin
          if (tdone) begin
            cs_oe   <= 1'b0;
            sk_oe   <= 1'b0;
            dio_oe  <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b1;
            rd_data <= op_write ? rd_data : rx_sel;
            st      <= SQ_IDLE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swcfg_serial_master_chk.sv
module swcfg_serial_master_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic cs_o,
  input logic cs_oe,
  input logic sk_o,
  input logic sk_oe,
  input logic dio_o,
  input logic dio_oe
);
  // R1: busy only starts after a request strobe
  p_busy_start_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));

  // R1: done is a single-cycle pulse that ends busy
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy));

  p_done_once_r1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2: transaction opens with all pins enabled and low
  p_open_low_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> cs_oe && sk_oe && dio_oe && !cs_o && !sk_o && !dio_o);

  // R3: data and chip select hold while the serial clock is high
  p_dio_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (sk_o && $past(sk_o)) |-> $stable(dio_o));

  p_cs_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (sk_o && $past(sk_o)) |-> $stable(cs_o));

  // R7: pins released whenever idle
  p_idle_release_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cs_oe && !sk_oe && !dio_oe);
endmodule

bind swcfg_serial_master swcfg_serial_master_chk u_chk (.*);

// File: tb/swcfg_serial_master_test.sv
module swcfg_serial_master_test;
  localparam int CPU  = 2;
  localparam int EU   = 3;
  localparam int MINW = CPU * EU;

  typedef struct packed {
    logic [45:0] bits;
    logic [6:0]  clen;
    logic [6:0]  tot;
    logic        wr;
    logic [31:0] rd;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_table = 1'b0;
  logic [7:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic busy, done, cs_o, cs_oe, sk_o, sk_oe, dio_o, dio_oe;
  logic dio_i = 1'b0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  exp_t sb[$];
  int n_done = 0;
  int n_push = 0;

  logic [31:0] slave_word = '0;
  int          cur_clen = 46;
  logic        cur_wr = 1'b0;

  always #2 clk = ~clk;

  swcfg_serial_master #(.CLK_PER_US(CPU), .EDGE_US(EU)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_table(req_table), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data),
    .cs_o(cs_o), .cs_oe(cs_oe), .sk_o(sk_o), .sk_oe(sk_oe),
    .dio_o(dio_o), .dio_oe(dio_oe), .dio_i(dio_i)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic exp_t build(input bit wr, input bit tbl, input logic [7:0] a,
                                 input logic [15:0] d, input logic [31:0] sw);
    exp_t e;
    e.wr = wr;
    if (wr) begin
      e.bits = {1'b1, 1'b0, 1'b1, a, d, 19'd0};
      e.clen = 7'd27;
      e.tot  = 7'd29;
      e.rd   = '0;
    end else begin
      e.bits = {32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1, 1'b0, tbl, 1'b0, 1'b0, a[6:0]};
      e.clen = 7'd46;
      e.tot  = 7'd80;
      if (tbl)       e.rd = sw;
      else if (a[0]) e.rd = {16'h0, sw[31:16]};
      else           e.rd = {16'h0, sw[15:0]};
    end
    return e;
  endfunction

  // monitor: link capture, target model, scoreboard pop
  int          rises = 0;
  logic [45:0] cap = '0;
  logic        prev_sk = 1'b0;
  int          since = 0;
  int          minw_seen = 1000;
  bit          cs_bad = 0, oe_bad = 0;

  always @(negedge clk) begin
    if (!rst) begin
      since++;
      if (sk_o !== prev_sk) begin
        if (busy && since < minw_seen) minw_seen = since;
        since = 0;
        if (sk_o) begin
          rises++;
          if (rises <= cur_clen) begin
            cap = {cap[44:0], dio_o};
            if (cs_o !== cur_wr) cs_bad = 1;
            if (dio_oe !== 1'b1) oe_bad = 1;
          end else begin
            if (cs_o !== 1'b0) cs_bad = 1;
            if (!cur_wr && rises <= cur_clen + 32 && dio_oe !== 1'b0) oe_bad = 1;
          end
        end else begin
          if (!cur_wr && rises >= cur_clen && rises < cur_clen + 32)
            dio_i = slave_word[31 - (rises - cur_clen)];
          else
            dio_i = 1'b0;
        end
        prev_sk = sk_o;
      end
      if (done) begin
        exp_t e;
        n_done++;
        if (sb.size() == 0) begin
          chk(0, "R1 unexpected done", 64'(n_done), 64'(n_push));
        end else begin
          e = sb.pop_front();
          if (e.wr) chk(cap[26:0] == e.bits[45:19], "R5 write frame", 64'(cap[26:0]), 64'(e.bits[45:19]));
          else      chk(cap == e.bits, "R4 read frame", 64'(cap), 64'(e.bits));
          chk(rises == int'(e.tot), "R7 clock pulse count", 64'(rises), 64'(e.tot));
          chk(!cs_bad, e.wr ? "R5 chip select level" : "R4 chip select level", 64'(cs_bad), 64'd0);
          chk(!oe_bad, "R6 data enable turnaround", 64'(oe_bad), 64'd0);
          chk(!busy && !cs_oe && !sk_oe && !dio_oe, "R7 release at done",
              64'({busy, cs_oe, sk_oe, dio_oe}), 64'd0);
          if (!e.wr) chk(rd_data == e.rd, "R8 R9 read result", 64'(rd_data), 64'(e.rd));
        end
        rises = 0; cap = '0; cs_bad = 0; oe_bad = 0;
      end
    end
  end

  task automatic txn(input bit wr, input bit tbl, input logic [7:0] a,
                     input logic [15:0] d, input logic [31:0] sw, input bit poke);
    exp_t e;
    e = build(wr, tbl, a, d, sw);
    sb.push_back(e);
    n_push++;
    slave_word = sw;
    cur_clen   = int'(e.clen);
    cur_wr     = wr;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_table = tbl; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R1 busy after accept", 64'(busy), 64'd1);
    chk({cs_oe, sk_oe, dio_oe, cs_o, sk_o, dio_o} === 6'b111000, "R2 opening pin state",
        64'({cs_oe, sk_oe, dio_oe, cs_o, sk_o, dio_o}), 64'h38);
    if (poke) begin
      repeat (200) @(negedge clk);
      req_valid = 1'b1; req_write = ~wr; req_addr = 8'h3C; req_wdata = 16'hAAAA;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk({busy, done, cs_oe, sk_oe, dio_oe} === 5'b0, "R1 R7 reset state",
        64'({busy, done, cs_oe, sk_oe, dio_oe}), 64'd0);

    txn(1'b0, 1'b0, 8'h45, 16'h0,    32'hA1B2_C3D4, 1'b0); // R8 odd
    txn(1'b0, 1'b0, 8'h12, 16'h0,    32'h1234_5678, 1'b1); // R8 even, R1 ignored request
    txn(1'b0, 1'b1, 8'h7F, 16'h0,    32'hDEAD_BEEF, 1'b0); // R9
    txn(1'b0, 1'b0, 8'hC5, 16'h0,    32'hA1B2_C3D4, 1'b0); // R10 bit 7 ignored
    txn(1'b1, 1'b0, 8'h11, 16'hFF30, 32'h0,         1'b1); // R5, R1 ignored request
    txn(1'b1, 1'b0, 8'hA5, 16'h1234, 32'h0,         1'b0); // R5
    txn(1'b0, 1'b1, 8'h00, 16'h0,    32'h8000_0001, 1'b0); // R9 edge bits

    chk(n_done == n_push, "R1 one done per accepted request", 64'(n_done), 64'(n_push));
    chk(sb.size() == 0, "R1 scoreboard drained", 64'(sb.size()), 64'd0);
    chk(minw_seen >= MINW, "R3 minimum phase width", 64'(minw_seen), 64'(MINW));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", n_done, n_push);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule